// File: doc/BRIEF.md
# Write-Masked Random Number Collection Register Block

This block is the register front end of a memory-mapped random-number peripheral on a 32-bit register bus. Software programs a sample period and a control word, then sets a start bit. The block samples an entropy source once per sample period and packs the bits into a bank of eight 32-bit result words. When the requested number of bits has been gathered, the start bit drops by itself. Software polls that bit and then reads the result words.

Writes to the control register are masked per bit. The upper half-word of the written value says which bits of the lower half-word may change, so one field can be updated without a read-modify-write. The analog oscillator rings are replaced by a deterministic 32-bit LFSR. The LFSR advances more slowly for the slower source selections.

Top module: `rng_regblk`

## Requirements
- R1: A write to the control register (word index 0, byte address 0x00) changes control bit i (i = 0..15) only when write-data bit 16+i is 1. Every other bit keeps its value. Reads of the control register return 0 in bits [31:6].
- R2: Control layout: bit 0 is start, bit 1 is enable, bits [3:2] select the source (0 fastest to 3 slowest) and bits [5:4] select the length (0, 1, 2, 3 give 64, 128, 192, 256 bits). All fields reset to 0.
- R3: The sample-count register (byte address 0x04) holds the 16 low bits of the written value and reads them back in bits [15:0], with zero above. It resets to 0.
- R4: A write that would leave start at 1 while enable is 0 leaves start at 0 and launches nothing.
- R5: After a launching write, start reads 1 for exactly L × P clock cycles and then returns to 0 by itself. L is the selected bit count and P is the sample count, with 0 treated as 1.
- R6: Result word k sits at byte address 0x10 + 4k (k = 0..7). It holds collected bits 32k to 32k+31, with the earliest bit in bit 31. Each collected bit is bit 0 of the LFSR at the end of a sample period. The LFSR is 32 bits wide and starts at 0x00000001 after reset. One step makes it {s[30:0], s[31]^s[21]^s[1]^s[0]}. It steps once every 2^source cycles while a run is active, and its divider restarts at each launch.
- R7: All result words are cleared when a run launches. Words beyond the selected length read zero.
- R8: Source, length and sample count are captured at launch. Writing them during a run does not change that run.
- R9: Writing start = 1 while a run is active neither restarts nor extends the run.
- R10: Clearing start, or clearing enable, by a masked write during a run ends the run at once, and the result words stop changing. A write of 0xFFFF0000 clears every control field.
- R11: The result words are read-only, and writes to them are ignored. Reads of unmapped addresses (for example 0x08 and 0x40) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (8) | Byte address; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The hardest situations to reach from the ports are bus writes that land in the middle of a run: a length change, a new sample count, a repeated start and an abort. Each needs exact cycle placement while the run is still collecting. The stimulus launches a run, waits a fixed number of cycles, issues the disturbing write, and measures the busy time from the launch edge with a cycle counter. The behavioural model tracks the collected bits on every clock, so any word that is latched early, late or after an abort shows up at once in the per-cycle comparison.

// File: rtl/rng_regblk_pkg.sv
package rng_regblk_pkg;

    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = 8;
    localparam int MAX_BITS  = MAX_WORDS * WORD_W;
    localparam int BITS_W    = $clog2(MAX_BITS + 1);
    localparam int CTRL_IDX  = 0;
    localparam int CNT_IDX   = 1;
    localparam int DATA_IDX0 = 4;
    localparam logic [31:0] LFSR_SEED = 32'h0000_0001;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_MID_A = 2'd1,
        SRC_MID_B = 2'd2,
        SRC_SLOW  = 2'd3
    } src_sel_t;

    typedef struct packed {
        logic [1:0] len;
        src_sel_t   src;
        logic       en;
        logic       start;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t ctrl_merge(input ctrl_t cur, input logic [31:0] wd);
        logic [CTRL_W-1:0] c;
        c = cur;
        for (int i = 0; i < CTRL_W; i++) begin
            if (wd[16+i]) c[i] = wd[i];
        end
        return ctrl_t'(c);
    endfunction

    function automatic logic [BITS_W-1:0] len_total(input logic [1:0] l);
        return ({{(BITS_W-2){1'b0}}, l} + BITS_W'(1)) << 6;
    endfunction

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/rng_src_lfsr.sv
module rng_src_lfsr
    import rng_regblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       running,
    input  logic [1:0] src_sel,
    output logic       bit_o
);

    logic [31:0] lfsr_q;
    logic [3:0]  div_q;
    logic [1:0]  sel_q;
    logic [3:0]  div_lim;

    always_comb begin
        div_lim = (4'd1 << sel_q) - 4'd1;
        bit_o   = lfsr_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= LFSR_SEED;
            div_q  <= '0;
            sel_q  <= '0;
        end else if (launch) begin
            div_q  <= '0;
            sel_q  <= src_sel;
        end else if (running) begin
            if (div_q == div_lim) begin
                div_q  <= '0;
                lfsr_q <= lfsr_step(lfsr_q);
            end else begin
                div_q  <= div_q + 4'd1;
            end
        end
    end

endmodule

// File: rtl/rng_collector.sv
module rng_collector
    import rng_regblk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               launch,
    input  logic                               running,
    input  logic [1:0]                         len_sel,
    input  logic [CNT_W-1:0]                   period,
    input  logic                               bit_i,
    output logic                               done_o,
    output logic [MAX_WORDS-1:0][WORD_W-1:0]   words_o
);

    localparam int BPW    = $clog2(WORD_W);
    localparam int WIDX_W = $clog2(MAX_WORDS);

    logic [CNT_W-1:0]  per_q, samp_q;
    logic [1:0]        len_q;
    logic [BITS_W-1:0] nbits_q;
    logic [WORD_W-1:0] acc_q, acc_nxt;
    logic              sample_now, word_full;
    logic [WIDX_W-1:0] widx;
    logic [BITS_W-1:0] last_bit;

    always_comb begin
        sample_now = running && (samp_q == per_q - CNT_W'(1));
        word_full  = sample_now && (&nbits_q[BPW-1:0]);
        widx       = nbits_q[BPW +: WIDX_W];
        acc_nxt    = {acc_q[WORD_W-2:0], bit_i};
        last_bit   = len_total(len_q) - BITS_W'(1);
        done_o     = sample_now && (nbits_q == last_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q   <= CNT_W'(1);
            samp_q  <= '0;
            len_q   <= '0;
            nbits_q <= '0;
            acc_q   <= '0;
        end else if (launch) begin
            per_q   <= (period == '0) ? CNT_W'(1) : period;
            samp_q  <= '0;
            len_q   <= len_sel;
            nbits_q <= '0;
            acc_q   <= '0;
        end else if (sample_now) begin
            samp_q  <= '0;
            nbits_q <= nbits_q + BITS_W'(1);
            acc_q   <= acc_nxt;
        end else if (running) begin
            samp_q  <= samp_q + CNT_W'(1);
        end
    end

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || launch) begin
                words_o[w] <= '0;
            end else if (word_full && widx == WIDX_W'(w)) begin
                words_o[w] <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/rng_regblk.sv
module rng_regblk
    import rng_regblk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int IW     = ADDR_W - 2;
    localparam int WIDX_W = $clog2(MAX_WORDS);

    ctrl_t                              ctrl_q, ctrl_base, ctrl_nxt;
    logic [CNT_W-1:0]                   cnt_q;
    logic [IW-1:0]                      widx, doff;
    logic                               wr_ctrl, wr_cnt, launch, coll_done, src_bit;
    logic                               run_busy, run_en;
    logic [MAX_WORDS-1:0][WORD_W-1:0]   data_words;

    always_comb begin
        widx    = bus_addr[ADDR_W-1:2];
        doff    = widx - IW'(DATA_IDX0);
        wr_ctrl = bus_we && (widx == IW'(CTRL_IDX));
        wr_cnt  = bus_we && (widx == IW'(CNT_IDX));

        ctrl_base = ctrl_q;
        if (coll_done) ctrl_base.start = 1'b0;
        ctrl_nxt = wr_ctrl ? ctrl_merge(ctrl_base, bus_wdata) : ctrl_base;
        if (!ctrl_nxt.en) ctrl_nxt.start = 1'b0;
        launch   = ctrl_nxt.start && !ctrl_base.start;
        run_busy = ctrl_q.start;
        run_en   = ctrl_q.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (wr_cnt) cnt_q <= bus_wdata[CNT_W-1:0];
        end
    end

    rng_src_lfsr u_src (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .running (ctrl_q.start),
        .src_sel (ctrl_nxt.src),
        .bit_o   (src_bit)
    );

    rng_collector #(.CNT_W(CNT_W)) u_coll (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .running (ctrl_q.start),
        .len_sel (ctrl_nxt.len),
        .period  (cnt_q),
        .bit_i   (src_bit),
        .done_o  (coll_done),
        .words_o (data_words)
    );

    always_comb begin
        bus_rdata = '0;
        if (widx == IW'(CTRL_IDX)) begin
            bus_rdata = 32'(ctrl_q);
        end else if (widx == IW'(CNT_IDX)) begin
            bus_rdata = 32'(cnt_q);
        end else if (widx >= IW'(DATA_IDX0) && widx < IW'(DATA_IDX0 + MAX_WORDS)) begin
            bus_rdata = data_words[doff[WIDX_W-1:0]];
        end
    end

endmodule

// File: rtl/rng_regblk_chk.sv
module rng_regblk_chk
    import rng_regblk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                             clk,
    input logic                             rst,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic                             bus_we,
    input logic [31:0]                      bus_rdata,
    input logic                             busy,
    input logic                             en,
    input logic                             done,
    input logic [MAX_WORDS-1:0][WORD_W-1:0] words
);

    assert_ctrl_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:2] == '0) |-> (bus_rdata[31:6] == '0));

    assert_start_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> en);

    assert_done_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_self_clear_cause_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(bus_we)) |-> $past(done));

    assert_launch_clears_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (words == '0));

    assert_idle_words_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(words));

endmodule

bind rng_regblk rng_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .busy      (run_busy),
    .en        (run_en),
    .done      (coll_done),
    .words     (data_words)
);

// File: tb/sim_rng_regblk.sv
`timescale 1ns/1ps
module sim_rng_regblk;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    rng_regblk u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // behavioural reference model
    bit        m_start, m_en;
    bit [1:0]  m_src, m_len, m_lsrc;
    bit [15:0] m_cnt;
    bit [31:0] m_data [8];
    bit [31:0] m_lfsr, m_acc;
    int        m_samp, m_div, m_nbits, m_total, m_per;

    function automatic bit [31:0] ref_step(bit [31:0] s);
        bit fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[30:0], fb};
    endfunction

    function automatic bit [31:0] model_read(bit [7:0] a);
        int idx;
        idx = a >> 2;
        if (idx == 0) return {26'd0, m_len, m_src, m_en, m_start};
        if (idx == 1) return {16'd0, m_cnt};
        if (idx >= 4 && idx < 12) return m_data[idx-4];
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_start = 0; m_en = 0; m_src = 0; m_len = 0; m_lsrc = 0; m_cnt = 0;
            foreach (m_data[i]) m_data[i] = 0;
            m_lfsr = 32'h1; m_acc = 0; m_samp = 0; m_div = 0; m_nbits = 0;
            m_total = 64; m_per = 1;
        end else begin
            bit done, b, ns, nen;
            bit [1:0] nsrc, nlen;
            done = 0;
            b = m_lfsr[0];
            if (m_start) begin
                if (m_samp == m_per - 1) begin
                    m_acc = {m_acc[30:0], b};
                    if (m_nbits % 32 == 31) m_data[m_nbits/32] = m_acc;
                    m_nbits++;
                    m_samp = 0;
                    if (m_nbits == m_total) done = 1;
                end else m_samp++;
                if (m_div == (1 << m_lsrc) - 1) begin
                    m_lfsr = ref_step(m_lfsr);
                    m_div = 0;
                end else m_div++;
            end
            ns = done ? 1'b0 : m_start;
            nen = m_en; nsrc = m_src; nlen = m_len;
            if (bus_we && (bus_addr >> 2) == 0) begin
                if (bus_wdata[16]) ns      = bus_wdata[0];
                if (bus_wdata[17]) nen     = bus_wdata[1];
                if (bus_wdata[18]) nsrc[0] = bus_wdata[2];
                if (bus_wdata[19]) nsrc[1] = bus_wdata[3];
                if (bus_wdata[20]) nlen[0] = bus_wdata[4];
                if (bus_wdata[21]) nlen[1] = bus_wdata[5];
            end
            if (!nen) ns = 0;
            if (ns && !(done ? 1'b0 : m_start)) begin
                foreach (m_data[i]) m_data[i] = 0;
                m_samp = 0; m_div = 0; m_nbits = 0; m_acc = 0;
                m_lsrc = nsrc;
                m_total = 64 * (int'(nlen) + 1);
                m_per = (m_cnt == 0) ? 1 : int'(m_cnt);
            end
            m_start = ns; m_en = nen; m_src = nsrc; m_len = nlen;
            if (bus_we && (bus_addr >> 2) == 1) m_cnt = bus_wdata[15:0];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            bit [31:0] e;
            string tag;
            e = model_read(bus_addr);
            tag = ((bus_addr >> 2) == 0) ? "R1" : ((bus_addr >> 2) == 1) ? "R3" :
                  ((bus_addr >> 2) >= 4 && (bus_addr >> 2) < 12) ? "R6" : "R11";
            tests++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s per-cycle addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input int t0, output int dur);
        @(negedge clk);
        bus_addr = 8'h00;
        for (int g = 0; g < 6000; g++) begin
            #2;
            if (bus_rdata[0] == 1'b0) break;
            @(negedge clk);
        end
        dur = cyc - t0;
    endtask

    task automatic chk_words(input string tag, input int nwords);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(8'h10 + 8'(4*i), v);
            if (i < nwords) chk(tag, v, m_data[i]);
            else chk("R7", v, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] snap [8];
        int t0, dur;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd(8'h00, v); chk("R2 reset ctrl", v, 32'h0);
        rd(8'h04, v); chk("R3 reset count", v, 32'h0);
        rd(8'h10, v); chk("R7 reset word", v, 32'h0);

        do_write(8'h04, 32'h0001_2345);
        rd(8'h04, v); chk("R3 count 16 bits", v, 32'h0000_2345);

        do_write(8'h00, 32'h0000_003E);
        rd(8'h00, v); chk("R1 unmasked write", v, 32'h0);

        do_write(8'h00, 32'h003C_0038);
        rd(8'h00, v); chk("R2 fields len=3 src=2", v, 32'h38);

        do_write(8'h00, 32'h0001_0001);
        rd(8'h00, v); chk("R4 start without enable", v, 32'h38);

        do_write(8'h00, 32'hFFFF_0000);
        rd(8'h00, v); chk("R10 full clear", v, 32'h0);

        // 64 bits, fastest source, period 3
        do_write(8'h04, 32'd3);
        do_write(8'h00, 32'hFFFF_0003); t0 = cyc;
        wait_idle(t0, dur); chk("R5 64x3", dur, 192);
        chk_words("R6 run 64", 2);

        // 256 bits, slowest source, period 2
        do_write(8'h04, 32'd2);
        do_write(8'h00, 32'hFFFF_003F); t0 = cyc;
        wait_idle(t0, dur); chk("R5 256x2", dur, 512);
        chk_words("R6 run 256", 8);

        // 128 bits, source 1, period 0 treated as 1; upper words cleared
        do_write(8'h04, 32'd0);
        do_write(8'h00, 32'hFFFF_0017); t0 = cyc;
        wait_idle(t0, dur); chk("R5 128x1", dur, 128);
        chk_words("R7 run 128", 4);

        // R8: settings changed mid-run do not alter the run
        do_write(8'h04, 32'd4);
        do_write(8'h00, 32'hFFFF_0003); t0 = cyc;
        repeat (10) @(negedge clk);
        do_write(8'h00, 32'h0030_0030);
        do_write(8'h04, 32'd50);
        wait_idle(t0, dur); chk("R8 latched length and count", dur, 256);
        rd(8'h00, v); chk("R8 length field kept", v, 32'h32);
        chk_words("R8 run data", 2);

        // R9: start again while busy
        do_write(8'h04, 32'd2);
        do_write(8'h00, 32'hFFFF_0003); t0 = cyc;
        repeat (20) @(negedge clk);
        do_write(8'h00, 32'h0001_0001);
        wait_idle(t0, dur); chk("R9 no restart", dur, 128);

        // R10: abort by full clear
        do_write(8'h04, 32'd5);
        do_write(8'h00, 32'hFFFF_003B);
        repeat (100) @(negedge clk);
        do_write(8'h00, 32'hFFFF_0000);
        rd(8'h00, v); chk("R10 abort clears ctrl", v, 32'h0);
        for (int i = 0; i < 8; i++) rd(8'h10 + 8'(4*i), snap[i]);
        repeat (50) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd(8'h10 + 8'(4*i), v); chk("R10 words frozen", v, snap[i]);
        end

        // R10: abort by clearing enable only
        do_write(8'h00, 32'hFFFF_0003);
        repeat (5) @(negedge clk);
        do_write(8'h00, 32'h0002_0000);
        rd(8'h00, v); chk("R10 enable clear stops run", v, 32'h0);

        // R11: read-only words, unmapped reads
        rd(8'h10, snap[0]);
        do_write(8'h10, 32'hDEAD_BEEF);
        rd(8'h10, v); chk("R11 word write ignored", v, snap[0]);
        rd(8'h08, v); chk("R11 unmapped 0x08", v, 32'h0);
        rd(8'h40, v); chk("R11 unmapped 0x40", v, 32'h0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule